// File: doc/BRIEF.md
# Two-Stage Cascaded Vectored Interrupt Controller

This block collects sixteen interrupt request lines in two eight-line stages. The primary stage serves lines 0 to 7 directly. One of its positions, picked by a one-hot cascade select, stands for the whole secondary stage, which serves lines 8 to 15. Each stage holds its own pending, mask and in-service registers, a vector base and a mode word. Requests are raised and dropped with per-line set and clear pulses.

The processor sees one combined interrupt-pending output and a sixteen-bit view of which lines are eligible. When it pulses `ack`, the block picks the highest-priority eligible line. It moves that line from pending to in-service and returns an 8-bit vector equal to the stage base plus the line's 3-bit index. An in-service line blocks itself and every lower-priority line of its stage until an end-of-interrupt command clears it, or until auto end-of-interrupt clears it at once.

Configuration goes through a single-cycle write port. `cfg_stage` picks the stage (0 = primary, 1 = secondary). `cfg_addr` picks the register: 0 is the mask (a 1 bit masks the line), 1 is the vector base, 2 is the mode word, and 3 is the cascade select, which exists for stage 0 only.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: Reset is synchronous and active high. It sets both masks to 0xFF, clears pending and in-service bits, sets the primary base to 0x08, the secondary base to 0x70, the cascade select to 0x04 and both mode words to 0, and clears `irq_out`, `pend_out` and `vec_valid`.
- R2: After a cycle with `ack` high, `vec_valid` is high for exactly one cycle. `vec_out` then holds the winning stage's base plus the 3-bit line index, modulo 256. A base written at address 1 takes effect on later acknowledges.
- R3: Let c be the lowest-numbered set in-service bit of a stage. That stage's lines c to 7 are then blocked. With no in-service bit set, nothing is blocked.
- R4: A line is eligible only when its pending bit is set, its mask bit (address 0, 1 = masked) is clear and it is not blocked. A request raised while masked stays pending and becomes eligible once unmasked.
- R5: The primary position selected by the cascade register (address 3, one-hot) reads as pending exactly while the secondary has an eligible line. Set and clear pulses on that primary line are ignored.
- R6: `pend_out[7:0]` shows the primary's eligible lines. `pend_out[15:8]` shows the secondary's eligible lines only while the primary's cascade position is itself eligible; otherwise those bits are 0. `pend_out` follows a state change by one cycle.
- R7: On `ack` the winner is the lowest-numbered eligible primary line. When that line is the cascade position, the winner is the lowest-numbered eligible secondary line instead. The winner's in-service bit is set and, in edge mode, its pending bit is cleared.
- R8: When a secondary line wins, the primary's cascade in-service bit is set as well. This blocks the cascade position and every higher-numbered primary line.
- R9: An `ack` with no eligible line returns 0xFF and changes no pending or in-service bit.
- R10: When mode bit 1 (auto end-of-interrupt) is set for a stage and a line of that stage wins, that stage's lowest set in-service bit is cleared in the same update. A secondary win does not apply the primary's auto end-of-interrupt.
- R11: A cycle with `eoi` high clears the lowest-numbered set in-service bit of the stage named by `eoi_stage` (0 = primary, 1 = secondary).
- R12: When mode bit 0 (level mode) is set for a stage, acknowledge leaves that stage's pending bits unchanged. Only a clear pulse removes a pending bit, so a line still raised is taken again after its end-of-interrupt.
- R13: `irq_out` is high exactly when some bit of `pend_out` is high, with the same one-cycle delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | 16 | Per-line raise pulses, bit n for line n |
| req_clr | input | 16 | Per-line drop pulses, bit n for line n |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_stage | input | 1 | Stage addressed by the write (0 primary, 1 secondary) |
| cfg_addr | input | 2 | Register: 0 mask, 1 base, 2 mode, 3 cascade select |
| cfg_wdata | input | 8 | Write data |
| ack | input | 1 | Processor acknowledge pulse |
| eoi | input | 1 | Non-specific end-of-interrupt pulse |
| eoi_stage | input | 1 | Stage the end-of-interrupt applies to |
| irq_out | output | 1 | Combined interrupt-pending flag |
| pend_out | output | 16 | Registered eligible-line view |
| vec_out | output | 8 | Vector returned for the last acknowledge |
| vec_valid | output | 1 | High the cycle after an acknowledge |

## Verification
Every single line is raised alone, taken and retired. This separates the two bases and shows that the cascade position is reached only through the secondary. Every ordered pair of lines is then raised together. The first acknowledge must match an arithmetic priority rank in which secondary lines sit between primary lines 1 and 3, and a second acknowledge must come back empty because of in-service blocking. Directed sequences add nested preemption, masked lines, gating by the cascade mask, auto end-of-interrupt, level-mode re-entry, a moved cascade position and rewritten bases; after each step the whole pending view is compared with a bench model.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  // configuration register selector
  typedef enum logic [1:0] {
    CFG_MASK = 2'd0,
    CFG_BASE = 2'd1,
    CFG_MODE = 2'd2,
    CFG_CASC = 2'd3
  } cfg_reg_e;

  // mode word bit positions
  localparam int MODE_LEVEL_BIT = 0;
  localparam int MODE_AEOI_BIT  = 1;
endpackage

// File: rtl/irq_lowest_pick.sv
// Isolates the lowest-numbered set bit of a vector.
module irq_lowest_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] hot_o,
  output logic         found_o
);
  assign hot_o   = vec_i & (~vec_i + N'(1));
  assign found_o = |vec_i;
endmodule

// File: rtl/irq_onehot_idx.sv
// Binary index of a one-hot vector.
module irq_onehot_idx #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  hot_i,
  output logic [IW-1:0] idx_o
);
  for (genvar b = 0; b < IW; b++) begin : g_bit
    logic [N-1:0] sel;
    for (genvar i = 0; i < N; i++) begin : g_pos
      if (((i >> b) % 2) == 1) begin : g_on
        assign sel[i] = hot_i[i];
      end else begin : g_off
        assign sel[i] = 1'b0;
      end
    end
    assign idx_o[b] = |sel;
  end
endmodule

// File: rtl/irq_stage.sv
// One eight-line stage: pending, mask, in-service, base and mode state.
module irq_stage
  import irq_cascade_pkg::*;
#(
  parameter int             N        = 8,
  parameter int             VW       = 8,
  parameter logic [VW-1:0]  BASE_RST = 8'h08
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  set_i,
  input  logic [N-1:0]  clr_i,
  input  logic          cfg_we_i,
  input  cfg_reg_e      cfg_addr_i,
  input  logic [VW-1:0] cfg_data_i,
  input  logic [N-1:0]  take_i,
  input  logic [N-1:0]  drop_i,
  input  logic          aeoi_trig_i,
  input  logic          eoi_i,
  input  logic [N-1:0]  ovr_sel_i,
  input  logic          ovr_val_i,
  output logic [N-1:0]  eff_o,
  output logic [N-1:0]  isr_o,
  output logic [VW-1:0] base_o,
  output logic          aeoi_o
);
  logic [N-1:0]  pend_q, mask_q, isr_q;
  logic [N-1:0]  pend_d, isr_d;
  logic [VW-1:0] base_q;
  logic          level_q, aeoi_q;

  // priority block derived from in-service bits
  logic [N-1:0] blk_hot, blk;
  logic         blk_any;
  irq_lowest_pick #(.N(N)) i_blk_pick (
    .vec_i(isr_q), .hot_o(blk_hot), .found_o(blk_any)
  );
  assign blk = blk_any ? ~(blk_hot - N'(1)) : '0;

  // pending view with optional override (cascade position)
  logic [N-1:0] pend_view;
  assign pend_view = (pend_q & ~ovr_sel_i) | (ovr_sel_i & {N{ovr_val_i}});
  assign eff_o     = pend_view & ~mask_q & ~blk;

  // pending next state
  always_comb begin
    pend_d = pend_q;
    if (!level_q) pend_d = pend_d & ~drop_i;
    pend_d = (pend_d | set_i) & ~clr_i;
  end

  // in-service next state: take, then auto-EOI, then explicit EOI
  logic [N-1:0] isr_take, isr_aeoi, hot_take, hot_aeoi;
  logic         any_take, any_aeoi;
  assign isr_take = isr_q | take_i;
  irq_lowest_pick #(.N(N)) i_take_pick (
    .vec_i(isr_take), .hot_o(hot_take), .found_o(any_take)
  );
  assign isr_aeoi = (aeoi_trig_i && aeoi_q && any_take) ? (isr_take & ~hot_take) : isr_take;
  irq_lowest_pick #(.N(N)) i_aeoi_pick (
    .vec_i(isr_aeoi), .hot_o(hot_aeoi), .found_o(any_aeoi)
  );
  assign isr_d = (eoi_i && any_aeoi) ? (isr_aeoi & ~hot_aeoi) : isr_aeoi;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      isr_q   <= '0;
      mask_q  <= '1;
      base_q  <= BASE_RST;
      level_q <= 1'b0;
      aeoi_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      isr_q  <= isr_d;
      if (cfg_we_i) begin
        case (cfg_addr_i)
          CFG_MASK: mask_q <= cfg_data_i[N-1:0];
          CFG_BASE: base_q <= cfg_data_i;
          CFG_MODE: begin
            level_q <= cfg_data_i[MODE_LEVEL_BIT];
            aeoi_q  <= cfg_data_i[MODE_AEOI_BIT];
          end
          default: ;
        endcase
      end
    end
  end

  assign isr_o  = isr_q;
  assign base_o = base_q;
  assign aeoi_o = aeoi_q;
endmodule

// File: rtl/irq_cascade_ctrl.sv
// Two-stage cascaded vectored interrupt controller.
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter int            N          = 8,
  parameter int            VW         = 8,
  parameter logic [VW-1:0] P_BASE_RST = 8'h08,
  parameter logic [VW-1:0] S_BASE_RST = 8'h70,
  parameter logic [N-1:0]  CASC_RST   = 8'h04
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2*N-1:0]  req_set,
  input  logic [2*N-1:0]  req_clr,
  input  logic            cfg_we,
  input  logic            cfg_stage,
  input  logic [1:0]      cfg_addr,
  input  logic [VW-1:0]   cfg_wdata,
  input  logic            ack,
  input  logic            eoi,
  input  logic            eoi_stage,
  output logic            irq_out,
  output logic [2*N-1:0]  pend_out,
  output logic [VW-1:0]   vec_out,
  output logic            vec_valid
);
  localparam int IW = $clog2(N);

  cfg_reg_e cfg_sel;
  assign cfg_sel = cfg_reg_e'(cfg_addr);

  // cascade select register (primary only)
  logic [N-1:0] casc_q;
  always_ff @(posedge clk) begin
    if (rst) casc_q <= CASC_RST;
    else if (cfg_we && !cfg_stage && cfg_sel == CFG_CASC) casc_q <= cfg_wdata[N-1:0];
  end

  logic [N-1:0]  eff_p, eff_s, isr_p, isr_s;
  logic [VW-1:0] base_p, base_s;
  logic          aeoi_p, aeoi_s;

  // winner selection
  logic [N-1:0]  p_hot, s_hot;
  logic          p_found, s_found, casc_win;
  logic [IW-1:0] p_idx, s_idx;

  irq_lowest_pick #(.N(N)) i_p_pick (.vec_i(eff_p), .hot_o(p_hot), .found_o(p_found));
  irq_lowest_pick #(.N(N)) i_s_pick (.vec_i(eff_s), .hot_o(s_hot), .found_o(s_found));
  irq_onehot_idx  #(.N(N), .IW(IW)) i_p_idx (.hot_i(p_hot), .idx_o(p_idx));
  irq_onehot_idx  #(.N(N), .IW(IW)) i_s_idx (.hot_i(s_hot), .idx_o(s_idx));

  assign casc_win = |(p_hot & casc_q);

  logic [N-1:0] take_p, drop_p, take_s;
  logic         trig_p, trig_s, sec_take;
  assign sec_take = ack && casc_win && s_found;
  assign take_p   = ack ? p_hot : '0;
  assign drop_p   = ack ? (p_hot & ~casc_q) : '0;
  assign take_s   = sec_take ? s_hot : '0;
  assign trig_p   = ack && p_found && !casc_win;
  assign trig_s   = sec_take;

  irq_stage #(.N(N), .VW(VW), .BASE_RST(P_BASE_RST)) i_primary (
    .clk        (clk),
    .rst        (rst),
    .set_i      (req_set[N-1:0] & ~casc_q),
    .clr_i      (req_clr[N-1:0] & ~casc_q),
    .cfg_we_i   (cfg_we && !cfg_stage),
    .cfg_addr_i (cfg_sel),
    .cfg_data_i (cfg_wdata),
    .take_i     (take_p),
    .drop_i     (drop_p),
    .aeoi_trig_i(trig_p),
    .eoi_i      (eoi && !eoi_stage),
    .ovr_sel_i  (casc_q),
    .ovr_val_i  (|eff_s),
    .eff_o      (eff_p),
    .isr_o      (isr_p),
    .base_o     (base_p),
    .aeoi_o     (aeoi_p)
  );

  irq_stage #(.N(N), .VW(VW), .BASE_RST(S_BASE_RST)) i_secondary (
    .clk        (clk),
    .rst        (rst),
    .set_i      (req_set[2*N-1:N]),
    .clr_i      (req_clr[2*N-1:N]),
    .cfg_we_i   (cfg_we && cfg_stage),
    .cfg_addr_i (cfg_sel),
    .cfg_data_i (cfg_wdata),
    .take_i     (take_s),
    .drop_i     (take_s),
    .aeoi_trig_i(trig_s),
    .eoi_i      (eoi && eoi_stage),
    .ovr_sel_i  ('0),
    .ovr_val_i  (1'b0),
    .eff_o      (eff_s),
    .isr_o      (isr_s),
    .base_o     (base_s),
    .aeoi_o     (aeoi_s)
  );

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out   <= 1'b0;
      pend_out  <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      irq_out   <= |eff_p;
      pend_out  <= {eff_s & {N{|(eff_p & casc_q)}}, eff_p};
      vec_valid <= ack;
      if (ack) begin
        if (!p_found)      vec_out <= '1;
        else if (casc_win) vec_out <= base_s + VW'(s_idx);
        else               vec_out <= base_p + VW'(p_idx);
      end
    end
  end
endmodule

// File: rtl/irq_cascade_chk.sv
// Property checker attached to the controller.
module irq_cascade_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           ack,
  input logic           eoi,
  input logic           irq_out,
  input logic [2*N-1:0] pend_out,
  input logic [7:0]     vec_out,
  input logic           vec_valid,
  input logic           any_now,
  input logic           casc_win,
  input logic [N-1:0]   casc_q,
  input logic [N-1:0]   isr_p,
  input logic           aeoi_p
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (pend_out == '0 && !irq_out && !vec_valid));

  p_vec_after_ack_r2: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(ack));

  p_hi_gated_r6: assert property (@(posedge clk) disable iff (rst)
    (pend_out[2*N-1:N] != '0) |-> ((pend_out[N-1:0] & $past(casc_q)) != '0));

  p_casc_isr_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && casc_win && !eoi) |=> ((isr_p & $past(casc_q)) != '0));

  p_empty_vec_r9: assert property (@(posedge clk) disable iff (rst)
    (ack && !any_now) |=> (vec_out == 8'hFF));

  p_isr_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!eoi && !aeoi_p) |=> ((isr_p & $past(isr_p)) == $past(isr_p)));

  p_irq_match_r13: assert property (@(posedge clk) disable iff (rst)
    irq_out == (pend_out[N-1:0] != '0));
endmodule

bind irq_cascade_ctrl irq_cascade_chk #(.N(N)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .ack      (ack),
  .eoi      (eoi),
  .irq_out  (irq_out),
  .pend_out (pend_out),
  .vec_out  (vec_out),
  .vec_valid(vec_valid),
  .any_now  (p_found),
  .casc_win (casc_win),
  .casc_q   (casc_q),
  .isr_p    (isr_p),
  .aeoi_p   (aeoi_p)
);

// File: tb/test_irq_cascade_ctrl.sv
module test_irq_cascade_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req_set, req_clr;
  logic        cfg_we, cfg_stage, ack, eoi, eoi_stage;
  logic [1:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic        irq_out, vec_valid;
  logic [15:0] pend_out;
  logic [7:0]  vec_out;

  always #5 clk = ~clk;

  irq_cascade_ctrl i_irq_cascade_ctrl (
    .clk(clk), .rst(rst), .req_set(req_set), .req_clr(req_clr),
    .cfg_we(cfg_we), .cfg_stage(cfg_stage), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ack(ack), .eoi(eoi), .eoi_stage(eoi_stage),
    .irq_out(irq_out), .pend_out(pend_out), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model state
  logic [7:0] m_pend[2], m_mask[2], m_isr[2], m_base[2], m_mode[2];
  logic [7:0] m_casc;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] blk(input logic [7:0] s);
    for (int c = 0; c < 8; c++) if (s[c]) return 8'hFF << c;
    return 8'h00;
  endfunction

  function automatic logic [7:0] clr_low(input logic [7:0] s);
    for (int c = 0; c < 8; c++) if (s[c]) return s & ~(8'h01 << c);
    return s;
  endfunction

  function automatic logic [7:0] m_eff_s();
    return m_pend[1] & ~m_mask[1] & ~blk(m_isr[1]);
  endfunction

  function automatic logic [7:0] m_eff_p();
    logic [7:0] v;
    v = m_pend[0] & ~m_casc;
    if (m_eff_s() != 0) v = v | m_casc;
    return v & ~m_mask[0] & ~blk(m_isr[0]);
  endfunction

  function automatic logic [15:0] exp_pend();
    logic [7:0] p;
    p = m_eff_p();
    return {((p & m_casc) != 0) ? m_eff_s() : 8'h00, p};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic model_reset();
    m_pend = '{8'h00, 8'h00}; m_isr = '{8'h00, 8'h00};
    m_mask = '{8'hFF, 8'hFF}; m_mode = '{8'h00, 8'h00};
    m_base = '{8'h08, 8'h70}; m_casc = 8'h04;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    model_reset();
    step();
  endtask

  task automatic check_state(string tag);
    logic [15:0] e;
    step();
    e = exp_pend();
    chk({tag, " pend_out"}, pend_out, e);
    chk("R13 irq_out", {15'd0, irq_out}, {15'd0, e != 0});
    chk("R2 vec_valid idle", {15'd0, vec_valid}, 16'd0);
  endtask

  task automatic raise(int ln);
    req_set[ln] = 1'b1; step(); req_set = '0;
    if (ln < 8) begin
      if (!m_casc[ln]) m_pend[0][ln] = 1'b1;
    end else m_pend[1][ln-8] = 1'b1;
  endtask

  task automatic lower(int ln);
    req_clr[ln] = 1'b1; step(); req_clr = '0;
    if (ln < 8) begin
      if (!m_casc[ln]) m_pend[0][ln] = 1'b0;
    end else m_pend[1][ln-8] = 1'b0;
  endtask

  task automatic cfg(int st, int a, logic [7:0] d);
    cfg_we = 1'b1; cfg_stage = st[0]; cfg_addr = a[1:0]; cfg_wdata = d;
    step(); cfg_we = 1'b0;
    case (a)
      0: m_mask[st] = d;
      1: m_base[st] = d;
      2: m_mode[st] = d;
      default: if (st == 0) m_casc = d;
    endcase
  endtask

  task automatic eoi_cmd(int st);
    eoi = 1'b1; eoi_stage = st[0]; step(); eoi = 1'b0;
    m_isr[st] = clr_low(m_isr[st]);
  endtask

  task automatic drain();
    while (m_isr[1] != 0) eoi_cmd(1);
    while (m_isr[0] != 0) eoi_cmd(0);
  endtask

  // acknowledge, compared with the model and with a literal expectation
  task automatic ack_expect(string tag, logic [7:0] lit);
    logic [7:0] p, s, v;
    bit hit;
    p = m_eff_p(); s = m_eff_s(); v = 8'hFF; hit = 0;
    for (int c = 0; c < 8; c++) begin
      if (!hit && p[c]) begin
        hit = 1;
        if (m_casc[c]) begin
          for (int d = 0; d < 8; d++) begin
            if (v == 8'hFF && s[d]) begin
              v = m_base[1] + 8'(d);
              if (!m_mode[1][0]) m_pend[1][d] = 1'b0;
              m_isr[1][d] = 1'b1;
              m_isr[0][c] = 1'b1;
              if (m_mode[1][1]) m_isr[1] = clr_low(m_isr[1]);
            end
          end
        end else begin
          v = m_base[0] + 8'(c);
          if (!m_mode[0][0]) m_pend[0][c] = 1'b0;
          m_isr[0][c] = 1'b1;
          if (m_mode[0][1]) m_isr[0] = clr_low(m_isr[0]);
        end
      end
    end
    ack = 1'b1; step(); ack = 1'b0;
    chk("R2 vec_valid after ack", {15'd0, vec_valid}, 16'd1);
    chk({tag, " model"}, {8'd0, vec_out}, {8'd0, v});
    chk({tag, " literal"}, {8'd0, vec_out}, {8'd0, lit});
  endtask

  function automatic logic [7:0] vec_of(int l);
    return (l < 8) ? 8'(8 + l) : 8'(8'h70 + l - 8);
  endfunction

  function automatic int rank(int l);
    if (l >= 8) return l - 6;
    return (l < 2) ? l : l + 8;
  endfunction

  initial begin
    req_set = '0; req_clr = '0; cfg_we = 0; cfg_stage = 0; cfg_addr = 0;
    cfg_wdata = 0; ack = 0; eoi = 0; eoi_stage = 0;
    do_reset();

    // R1 reset state
    chk("R1 pend_out reset", pend_out, 16'h0000);
    chk("R1 irq_out reset", {15'd0, irq_out}, 16'd0);
    chk("R1 vec_valid reset", {15'd0, vec_valid}, 16'd0);
    raise(0);
    check_state("R1 mask all ones");
    chk("R1 masked line hidden", pend_out, 16'h0000);
    cfg(0, 0, 8'h00); cfg(1, 0, 8'h00);
    check_state("R4 latched while masked");
    chk("R4 unmask shows line 0", pend_out, 16'h0001);
    ack_expect("R1 primary base 8", 8'h08);
    drain();

    // R9 empty acknowledge
    ack_expect("R9 empty", 8'hFF);
    check_state("R9 no state change");

    // R3 nesting and R11 end-of-interrupt
    raise(5); ack_expect("R7 line 5", 8'h0D);
    raise(6); ack_expect("R3 lower blocked", 8'hFF);
    raise(3); ack_expect("R3 higher preempts", 8'h0B);
    eoi_cmd(0);
    ack_expect("R11 eoi cleared lowest only", 8'hFF);
    eoi_cmd(0);
    ack_expect("R11 line 6 after eoi", 8'h0E);
    drain(); check_state("R11 drained");

    // R4 programmed mask
    cfg(0, 0, 8'h02); raise(1);
    check_state("R4 masked line");
    ack_expect("R4 masked ack", 8'hFF);
    cfg(0, 0, 8'h00);
    check_state("R4 unmasked");
    chk("R4 line 1 visible", pend_out, 16'h0002);
    ack_expect("R4 line 1", 8'h09); drain();

    // R5 / R6 / R8 cascade
    raise(2); check_state("R5 cascade line ignored");
    chk("R5 set on cascade line", pend_out, 16'h0000);
    raise(12); check_state("R5 cascade follows secondary");
    chk("R6 both halves", pend_out, 16'h1004);
    cfg(0, 0, 8'h04); check_state("R6 cascade masked");
    chk("R6 high half gated", pend_out, 16'h0000);
    cfg(0, 0, 8'h00);
    lower(12); check_state("R5 secondary cleared");
    chk("R5 cascade bit dropped", pend_out, 16'h0000);
    raise(12); ack_expect("R8 secondary line 12", 8'h74);
    raise(3); ack_expect("R8 cascade in service blocks 3", 8'hFF);
    raise(1); ack_expect("R8 line 1 still above", 8'h09);
    drain(); ack_expect("R7 line 3 after drain", 8'h0B); drain();
    check_state("R8 drained");

    // R10 auto end-of-interrupt
    cfg(0, 2, 8'h02);
    raise(5); ack_expect("R10 line 5", 8'h0D);
    raise(6); ack_expect("R10 not blocked", 8'h0E);
    chk("R10 in-service empty", {8'd0, m_isr[0]}, 16'd0);
    ack_expect("R10 nothing left", 8'hFF);
    cfg(0, 2, 8'h00);

    // R12 level mode
    cfg(0, 2, 8'h01);
    raise(4); ack_expect("R12 first take", 8'h0C);
    ack_expect("R12 blocked while in service", 8'hFF);
    eoi_cmd(0); ack_expect("R12 retaken", 8'h0C);
    eoi_cmd(0); lower(4); ack_expect("R12 cleared by pulse", 8'hFF);
    cfg(0, 2, 8'h00); check_state("R12 done");

    // R2 base rewrite
    cfg(0, 1, 8'h20); raise(7); ack_expect("R2 primary base 0x20", 8'h27); drain();
    cfg(1, 1, 8'h40); raise(15); ack_expect("R2 secondary base 0x40", 8'h47); drain();
    cfg(0, 1, 8'h08); cfg(1, 1, 8'h70);

    // R5 moved cascade position
    cfg(0, 3, 8'h80);
    raise(2); raise(9); check_state("R5 cascade at 7");
    chk("R5 moved view", pend_out, 16'h0284);
    ack_expect("R7 line 2 above cascade 7", 8'h0A); drain();
    ack_expect("R7 secondary via 7", 8'h71); drain();
    cfg(0, 3, 8'h04); check_state("R5 restored");

    // single-line sweep
    do_reset(); cfg(0, 0, 8'h00); cfg(1, 0, 8'h00);
    for (int l = 0; l < 16; l++) begin
      if (l == 2) continue;
      raise(l); check_state("R6 single");
      ack_expect("R2 single vector", vec_of(l));
      drain(); check_state("R11 single drained");
    end

    // pair sweep
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        if (i == j || i == 2 || j == 2) continue;
        raise(i); raise(j); check_state("R6 pair");
        ack_expect("R7 pair winner", vec_of(rank(i) < rank(j) ? i : j));
        ack_expect("R3 pair loser blocked", 8'hFF);
        drain();
        ack_expect("R7 pair loser", vec_of(rank(i) < rank(j) ? j : i));
        drain(); check_state("R11 pair drained");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule